// File: doc/BRIEF.md
# Read Prefetch Burst Controller

This block decides how much data a memory read pulls into a read FIFO. A requester presents a read with a command type (plain, multiple or line), a direction flag (upstream or downstream), a flag that marks the address window as prefetchable, and a word address. The controller then issues fetch strobes. Each strobe asks for either the single requested word or one whole cache line. It keeps issuing strobes until the chosen burst length is reached.

The burst length is chosen at run time. A plain read, or any read to a non-prefetchable window, moves one word. An upstream multiple/line read moves exactly one cache line, unless the upstream multi-line enable is set and the separate override bit is clear. In that case it streams line after line until the FIFO can take no further line. A downstream multiple/line read to a prefetchable window streams the same way when the downstream burst enable is set. With that enable clear, it falls back to a single word.

The controller reserves FIFO space for each fetch and releases it as the consumer pops words. A fetch starts only when the space it needs is free. If the requester terminates a burst, the block stops fetching and flushes all prefetched words.

Top module: `read_prefetch_ctrl`

## Requirements
- R1: While reset is held and directly after it, fetch_start, fetch_single, burst_stop, flush and busy are 0, burst_lines is 0 and fifo_free equals the FIFO depth (32 words).
- R2: A request with req_cmd 2'b00 (plain) or 2'b11 (treated as plain) issues exactly one fetch. That fetch has fetch_single=1 and fetch_addr equal to req_addr. burst_stop is asserted in the same cycle, burst_lines stays 0 and fifo_free drops by 1.
- R3: A request with req_prefetchable=0 issues a single-word fetch as in R2, whatever its command or direction.
- R4: An upstream (req_upstream=1) read with req_cmd 2'b01 (multiple) or 2'b10 (line) to a prefetchable window, with cfg_up_multi_en=0, issues exactly one line fetch. That fetch has fetch_single=0 and fetch_addr equal to req_addr with its low 3 bits cleared. burst_stop comes with it and burst_lines becomes 1.
- R5: The same upstream read with cfg_up_multi_en=1 and cfg_multi_override=0 issues line fetches at consecutive line addresses, each 8 above the last. It stops, with burst_stop alongside the last fetch, once fewer than 8 words would remain free. From an empty FIFO this is 4 lines.
- R6: With cfg_multi_override=1, an upstream multiple/line read issues a single line as in R4, even when cfg_up_multi_en=1.
- R7: A downstream (req_upstream=0) prefetchable multiple/line read streams lines as in R5 when cfg_down_burst_en=1. When cfg_down_burst_en=0 it issues a single-word fetch.
- R8: A line fetch starts only when fifo_free is at least 8 (one word for a single-word fetch). Until then the request stays pending with busy=1, and the fetch starts once enough words have been popped.
- R9: req_term asserted while busy stops the burst: no further fetch_start, and flush and burst_stop pulse together on the next cycle. Flushing returns fifo_free to the full depth. req_term while idle has no effect.
- R10: Each cycle with fifo_pop=1 raises fifo_free by one word.
- R11: req_valid is ignored while busy. A request offered mid-burst adds no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request offered (taken only when idle) |
| req_cmd | input | 2 | 00 plain, 01 multiple, 10 line, 11 treated as plain |
| req_upstream | input | 1 | 1 = upstream read, 0 = downstream read |
| req_prefetchable | input | 1 | Address lies in a prefetchable window |
| req_addr | input | ADDR_W | Requested word address |
| req_term | input | 1 | Requester terminates the burst |
| fifo_pop | input | 1 | One word consumed from the read FIFO |
| cfg_up_multi_en | input | 1 | Upstream multi-line burst enable |
| cfg_down_burst_en | input | 1 | Downstream burst enable |
| cfg_multi_override | input | 1 | Override; when 1, upstream multi-line streaming is blocked |
| fetch_start | output | 1 | One-cycle fetch strobe |
| fetch_addr | output | ADDR_W | Word address of the fetch (line-aligned for line fetches) |
| fetch_single | output | 1 | Fetch is a single word rather than a line |
| burst_stop | output | 1 | Burst has ended this cycle |
| flush | output | 1 | Prefetched data is discarded |
| busy | output | 1 | A request is being served |
| burst_lines | output | LINE_CNT_W | Lines issued in the current or last burst |
| fifo_free | output | clog2(depth+1) | Free words in the read FIFO |

## Verification
The assertions assume that the consumer never pops from an empty FIFO. The space counter therefore never underflows, and a pop always implies fifo_free below the depth. They also assume that no two bursts can produce fetch strobes on adjacent cycles, which holds because a burst must go idle for one cycle before the next request is taken. The stimulus respects the first assumption: every drain pops exactly the number of words the preceding bursts reserved, and no pop is issued while a stream is running.

// File: rtl/rfp_pkg.sv
package rfp_pkg;

  localparam logic [1:0] CMD_PLAIN = 2'b00;
  localparam logic [1:0] CMD_MULT  = 2'b01;
  localparam logic [1:0] CMD_LINE  = 2'b10;

  typedef enum logic [1:0] {
    MODE_WORD   = 2'd0,
    MODE_LINE   = 2'd1,
    MODE_STREAM = 2'd2
  } fetch_mode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ISSUE = 1'b1
  } seq_state_e;

endpackage

// File: rtl/rfp_policy.sv
module rfp_policy
  import rfp_pkg::*;
(
  input  logic [1:0]  cmd,
  input  logic        upstream,
  input  logic        prefetchable,
  input  logic        up_multi_en,
  input  logic        multi_override,
  input  logic        down_burst_en,
  output fetch_mode_e mode
);

  logic burst_cmd;

  assign burst_cmd = (cmd == CMD_MULT) || (cmd == CMD_LINE);

  always_comb begin
    mode = MODE_WORD;
    if (burst_cmd && prefetchable) begin
      if (upstream) begin
        mode = (up_multi_en && !multi_override) ? MODE_STREAM : MODE_LINE;
      end else begin
        mode = down_burst_en ? MODE_STREAM : MODE_WORD;
      end
    end
  end

endmodule

// File: rtl/rfp_space.sv
module rfp_space #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reserve,
  input  logic [CNT_W-1:0] reserve_words,
  input  logic             pop,
  input  logic             clear,
  output logic [CNT_W-1:0] free_words
);

  logic [CNT_W-1:0] taken;
  logic [CNT_W-1:0] given;

  assign taken = reserve ? reserve_words : '0;
  assign given = CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      free_words <= CNT_W'(DEPTH);
    end else begin
      free_words <= free_words - taken + given;
    end
  end

endmodule

// File: rtl/rfp_seq.sv
module rfp_seq
  import rfp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 8,
  parameter int DEPTH      = 32,
  parameter int LINE_CNT_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [ADDR_W-1:0]     req_addr,
  input  fetch_mode_e           req_mode,
  input  logic                  req_term,
  input  logic [CNT_W-1:0]      free_words,
  output logic                  reserve,
  output logic [CNT_W-1:0]      reserve_words,
  output logic                  clear,
  output logic                  fetch_start,
  output logic [ADDR_W-1:0]     fetch_addr,
  output logic                  fetch_single,
  output logic                  burst_stop,
  output logic                  flush,
  output logic                  busy,
  output logic [LINE_CNT_W-1:0] burst_lines
);

  seq_state_e       state;
  fetch_mode_e      mode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] line_base;
  logic             room;
  logic             issue;
  logic             last;
  logic             word_mode;

  generate
    if (OFF_W > 0) begin : g_align
      assign line_base = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else begin : g_noalign
      assign line_base = req_addr;
    end
  endgenerate

  assign word_mode     = (mode_q == MODE_WORD);
  assign room          = word_mode ? (free_words != '0)
                                   : (free_words >= CNT_W'(LINE_WORDS));
  assign issue         = (state == ST_ISSUE) && !req_term && room;
  assign last          = (mode_q != MODE_STREAM) ||
                         ({1'b0, free_words} < (CNT_W + 1)'(2 * LINE_WORDS));
  assign reserve       = issue;
  assign reserve_words = word_mode ? CNT_W'(1) : CNT_W'(LINE_WORDS);
  assign clear         = (state == ST_ISSUE) && req_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      mode_q       <= MODE_WORD;
      addr_q       <= '0;
      fetch_start  <= 1'b0;
      fetch_addr   <= '0;
      fetch_single <= 1'b0;
      burst_stop   <= 1'b0;
      flush        <= 1'b0;
      busy         <= 1'b0;
      burst_lines  <= '0;
    end else begin
      fetch_start <= 1'b0;
      burst_stop  <= 1'b0;
      flush       <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state       <= ST_ISSUE;
            busy        <= 1'b1;
            mode_q      <= req_mode;
            addr_q      <= (req_mode == MODE_WORD) ? req_addr : line_base;
            burst_lines <= '0;
          end
        end
        ST_ISSUE: begin
          if (req_term) begin
            flush      <= 1'b1;
            burst_stop <= 1'b1;
            busy       <= 1'b0;
            state      <= ST_IDLE;
          end else if (issue) begin
            fetch_start  <= 1'b1;
            fetch_addr   <= addr_q;
            fetch_single <= word_mode;
            addr_q       <= addr_q + ADDR_W'(LINE_WORDS);
            if (!word_mode) begin
              burst_lines <= burst_lines + LINE_CNT_W'(1);
            end
            if (last) begin
              burst_stop <= 1'b1;
              busy       <= 1'b0;
              state      <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/read_prefetch_ctrl.sv
module read_prefetch_ctrl
  import rfp_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 8,
  parameter int FIFO_LINES = 4,
  parameter int LINE_CNT_W = 8
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          req_valid,
  input  logic [1:0]                                    req_cmd,
  input  logic                                          req_upstream,
  input  logic                                          req_prefetchable,
  input  logic [ADDR_W-1:0]                             req_addr,
  input  logic                                          req_term,
  input  logic                                          fifo_pop,
  input  logic                                          cfg_up_multi_en,
  input  logic                                          cfg_down_burst_en,
  input  logic                                          cfg_multi_override,
  output logic                                          fetch_start,
  output logic [ADDR_W-1:0]                             fetch_addr,
  output logic                                          fetch_single,
  output logic                                          burst_stop,
  output logic                                          flush,
  output logic                                          busy,
  output logic [LINE_CNT_W-1:0]                         burst_lines,
  output logic [$clog2(LINE_WORDS*FIFO_LINES+1)-1:0]    fifo_free
);

  localparam int DEPTH = LINE_WORDS * FIFO_LINES;
  localparam int CNT_W = $clog2(DEPTH + 1);

  fetch_mode_e      req_mode;
  logic             reserve;
  logic [CNT_W-1:0] reserve_words;
  logic             clear;

  rfp_policy u_policy (
    .cmd            (req_cmd),
    .upstream       (req_upstream),
    .prefetchable   (req_prefetchable),
    .up_multi_en    (cfg_up_multi_en),
    .multi_override (cfg_multi_override),
    .down_burst_en  (cfg_down_burst_en),
    .mode           (req_mode)
  );

  rfp_space #(.DEPTH(DEPTH)) u_space (
    .clk           (clk),
    .rst           (rst),
    .reserve       (reserve),
    .reserve_words (reserve_words),
    .pop           (fifo_pop),
    .clear         (clear),
    .free_words    (fifo_free)
  );

  rfp_seq #(
    .ADDR_W     (ADDR_W),
    .LINE_WORDS (LINE_WORDS),
    .DEPTH      (DEPTH),
    .LINE_CNT_W (LINE_CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_mode      (req_mode),
    .req_term      (req_term),
    .free_words    (fifo_free),
    .reserve       (reserve),
    .reserve_words (reserve_words),
    .clear         (clear),
    .fetch_start   (fetch_start),
    .fetch_addr    (fetch_addr),
    .fetch_single  (fetch_single),
    .burst_stop    (burst_stop),
    .flush         (flush),
    .busy          (busy),
    .burst_lines   (burst_lines)
  );

endmodule

// File: rtl/read_prefetch_ctrl_chk.sv
module read_prefetch_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int LINE_WORDS = 8,
  parameter int FIFO_LINES = 4,
  localparam int DEPTH = LINE_WORDS * FIFO_LINES,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rst,
  input logic              fifo_pop,
  input logic              fetch_start,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_single,
  input logic              burst_stop,
  input logic              flush,
  input logic              busy,
  input logic [CNT_W-1:0]  fifo_free
);

  // R8
  line_room_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_start && !fetch_single) |-> ($past(fifo_free) >= CNT_W'(LINE_WORDS)));

  // R4
  line_align_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_start && !fetch_single) |-> (fetch_addr[OFF_W-1:0] == '0));

  // R5
  stream_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fetch_start && $past(fetch_start) && !fetch_single)
      |-> (fetch_addr == $past(fetch_addr) + ADDR_W'(LINE_WORDS)));

  // R9
  flush_stop_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (burst_stop && !fetch_start && !busy));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> (fifo_free == CNT_W'(DEPTH)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> !fetch_start);

  // R10
  pop_legal_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (fifo_free < CNT_W'(DEPTH)));

endmodule

bind read_prefetch_ctrl read_prefetch_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_WORDS (LINE_WORDS),
  .FIFO_LINES (FIFO_LINES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fifo_pop     (fifo_pop),
  .fetch_start  (fetch_start),
  .fetch_addr   (fetch_addr),
  .fetch_single (fetch_single),
  .burst_stop   (burst_stop),
  .flush        (flush),
  .busy         (busy),
  .fifo_free    (fifo_free)
);

// File: tb/read_prefetch_ctrl_test.sv
`timescale 1ns/1ps
module read_prefetch_ctrl_test;

  localparam int ADDR_W = 16;
  localparam int DEPTH  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [1:0]        req_cmd = 2'b00;
  logic              req_upstream = 1'b0;
  logic              req_prefetchable = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              req_term = 1'b0;
  logic              fifo_pop = 1'b0;
  logic              cfg_up_multi_en = 1'b0;
  logic              cfg_down_burst_en = 1'b1;
  logic              cfg_multi_override = 1'b0;
  logic              fetch_start;
  logic [ADDR_W-1:0] fetch_addr;
  logic              fetch_single;
  logic              burst_stop;
  logic              flush;
  logic              busy;
  logic [7:0]        burst_lines;
  logic [5:0]        fifo_free;

  int checks = 0;
  int fails  = 0;

  read_prefetch_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_upstream(req_upstream), .req_prefetchable(req_prefetchable),
    .req_addr(req_addr), .req_term(req_term), .fifo_pop(fifo_pop),
    .cfg_up_multi_en(cfg_up_multi_en), .cfg_down_burst_en(cfg_down_burst_en),
    .cfg_multi_override(cfg_multi_override), .fetch_start(fetch_start),
    .fetch_addr(fetch_addr), .fetch_single(fetch_single),
    .burst_stop(burst_stop), .flush(flush), .busy(busy),
    .burst_lines(burst_lines), .fifo_free(fifo_free)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic        up;
    logic [1:0]  cmd;
    logic        pref;
    logic        up_en;
    logic        ovr;
    logic        dn_en;
    logic [15:0] addr;
    logic [3:0]  exp_n;
    logic        exp_single;
    logic [15:0] exp_addr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0123, 4'd1, 1'b1, 16'h0123}, // R2
    '{1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0123, 4'd1, 1'b1, 16'h0123}, // R3
    '{1'b0, 2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0456, 4'd1, 1'b1, 16'h0456}, // R3
    '{1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0123, 4'd1, 1'b0, 16'h0120}, // R4
    '{1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0123, 4'd4, 1'b0, 16'h0120}, // R5
    '{1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0123, 4'd1, 1'b0, 16'h0120}, // R6
    '{1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0457, 4'd4, 1'b0, 16'h0450}, // R7
    '{1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0457, 4'd1, 1'b1, 16'h0457}, // R7
    '{1'b1, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0089, 4'd1, 1'b1, 16'h0089}  // R2
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drain(input int n);
    if (n > 0) begin
      @(negedge clk);
      fifo_pop = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      fifo_pop = 1'b0;
    end
  endtask

  task automatic request(input logic up, input logic [1:0] cmd, input logic pref,
                         input logic [15:0] addr);
    @(negedge clk);
    req_upstream = up;
    req_cmd = cmd;
    req_prefetchable = pref;
    req_addr = addr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input bit do_drain);
    int n = 0;
    int words;
    bit stopped = 1'b0;
    bit sgl = 1'b0;
    logic [15:0] first = '0;
    logic [15:0] prev = '0;
    cfg_up_multi_en = v.up_en;
    cfg_multi_override = v.ovr;
    cfg_down_burst_en = v.dn_en;
    request(v.up, v.cmd, v.pref, v.addr);
    for (int c = 0; c < 20 && !stopped; c++) begin
      @(negedge clk);
      if (fetch_start) begin
        if (n == 0) begin
          first = fetch_addr;
          sgl = fetch_single;
        end else begin
          check(fetch_addr == prev + 16'd8, "R5 consecutive line address",
                int'(fetch_addr), int'(prev + 16'd8));
        end
        prev = fetch_addr;
        n++;
      end
      if (burst_stop) stopped = 1'b1;
    end
    words = v.exp_single ? 1 : 8 * int'(v.exp_n);
    check(n == int'(v.exp_n), "R2-R7 fetch count", n, int'(v.exp_n));
    check(first == v.exp_addr, "R2/R4 first fetch address", int'(first), int'(v.exp_addr));
    check(sgl == v.exp_single, "R2/R4 fetch_single", int'(sgl), int'(v.exp_single));
    check(int'(burst_lines) == (v.exp_single ? 0 : int'(v.exp_n)), "R4 burst_lines",
          int'(burst_lines), v.exp_single ? 0 : int'(v.exp_n));
    check(int'(fifo_free) == DEPTH - words, "R10 fifo_free after burst",
          int'(fifo_free), DEPTH - words);
    check(!busy, "R5 busy clear after stop", int'(busy), 0);
    if (do_drain) drain(words);
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog R1 run hung actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int cnt;
    bit any;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(!fetch_start && !busy && !flush && !burst_stop, "R1 strobes in reset",
          int'({fetch_start, busy, flush, burst_stop}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(int'(fifo_free) == DEPTH, "R1 fifo_free after reset", int'(fifo_free), DEPTH);
    check(burst_lines == 0 && !fetch_single, "R1 burst_lines after reset",
          int'(burst_lines), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b1);

    // R8: line request waits for room, R10: pops free space
    run_vec(VECS[4], 1'b0);
    drain(4);
    check(int'(fifo_free) == 4, "R10 fifo_free after 4 pops", int'(fifo_free), 4);
    cfg_up_multi_en = 1'b0;
    request(1'b1, 2'b01, 1'b1, 16'h0208);
    any = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (fetch_start) any = 1'b1;
    end
    check(!any && busy, "R8 no fetch without room", int'(any), 0);
    drain(4);
    any = 1'b0;
    for (int c = 0; c < 4 && !any; c++) begin
      if (fetch_start) begin
        any = 1'b1;
        check(fetch_addr == 16'h0208, "R8 waited fetch address", int'(fetch_addr), 'h208);
      end else begin
        @(negedge clk);
      end
    end
    check(any, "R8 fetch after room appears", int'(any), 1);
    check(int'(fifo_free) == 0, "R8 fifo_free after waited line", int'(fifo_free), 0);
    drain(32);

    // R9: termination mid-stream
    cfg_up_multi_en = 1'b1;
    cfg_multi_override = 1'b0;
    request(1'b1, 2'b10, 1'b1, 16'h0040);
    @(negedge clk);
    check(fetch_start && fetch_addr == 16'h0040, "R9 first line before terminate",
          int'(fetch_addr), 'h40);
    req_term = 1'b1;
    @(negedge clk);
    req_term = 1'b0;
    check(flush && burst_stop && !fetch_start, "R9 flush and stop",
          int'({flush, burst_stop, fetch_start}), 6);
    check(int'(fifo_free) == DEPTH && !busy, "R9 space returned", int'(fifo_free), DEPTH);
    any = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (fetch_start) any = 1'b1;
    end
    check(!any, "R9 no fetch after terminate", int'(any), 0);

    // R11: request offered mid-burst is ignored
    request(1'b1, 2'b10, 1'b1, 16'h0100);
    cnt = 0;
    @(negedge clk);
    if (fetch_start) cnt++;
    req_cmd = 2'b00;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (fetch_start) cnt++;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (fetch_start) cnt++;
    end
    check(cnt == 4, "R11 mid-burst request adds no fetch", cnt, 4);

    // R9: req_term while idle has no effect
    @(negedge clk);
    req_term = 1'b1;
    @(negedge clk);
    req_term = 1'b0;
    @(negedge clk);
    check(!flush && int'(fifo_free) == 0, "R9 idle terminate ignored",
          int'(fifo_free), 0);
    drain(32);
    check(int'(fifo_free) == DEPTH, "R10 full drain", int'(fifo_free), DEPTH);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule